// File: doc/BRIEF.md
# Multi-Core Wake-Up Stagger Arbiter

A shared controller that sits beside the power-gating controllers of a small grid of cores. A gated core that needs to wake up raises a mode request. The arbiter records the request and picks one pending core at a time in round-robin order. It issues a one-cycle wake-start permission to that core, together with the wake-up mode granted to it. Only one core may start waking in any cycle. After each start, further starts are held back by a programmable stagger of whole base time units, where one base unit equals one clock cycle. This keeps the inrush of several cores waking together from stretching everyone's wake-up latency.

Two modes exist: aggressive, which allows a faster wake with more peak current, and conservative. The aggressive mode is granted only when the system utilization input is below a programmable threshold and no grid neighbour of the requester is still waking. The arbiter tracks which cores are waking. A core enters that state when it receives a start permission and leaves it when it reports completion. A core that is not marked idle is never granted.

Top module: `wake_stagger_arbiter`

## Requirements
- R1: After reset no permission or mode bit is asserted, no core is pending or waking, and the round-robin search starts at core 0.
- R2: A request from a core that is idle and not waking is captured on the clock edge that samples it. The earliest permission for that core appears as a one-cycle pulse after the following edge. A request held over several cycles yields one permission only.
- R3: At most one permission bit is high in any cycle. When starts contend, successive permissions are exactly S+1 cycles apart, where S is the `stagger_i` value (0 to 3) sampled on the edge that issued the earlier permission. A value of 0 therefore gives back-to-back starts.
- R4: The search for the next winner begins at the core numbered one above the last winner, wrapping from the highest core to core 0.
- R5: Cores are numbered row-major, index = y*GRID_X + x, and two cores are adjacent when their grid Manhattan distance is 1. On the default 2x2 grid, cores whose indices differ in exactly one bit are adjacent. The granted mode is aggressive (`mode_o` bit = 1) exactly when `util_i < util_thresh_i` and no core adjacent to the winner is waking. Otherwise it is conservative (bit = 0). A `mode_o` bit is never high without its permission bit.
- R6: A request from a core whose `idle_i` bit is low is ignored and leaves nothing pending. A pending core whose `idle_i` bit is low when arbitration happens is skipped, but it keeps its pending request and is served once idle again.
- R7: A core stays waking from its permission until a cycle with its `done_i` bit high. Requests from a waking core are ignored. After completion, a new request is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one period is one stagger base unit |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idle_i | input | NC | Per-core idle (power-gated) status |
| req_i | input | NC | Per-core wake-up mode request |
| done_i | input | NC | Per-core wake-up completion |
| util_i | input | UTIL_W | System utilization level |
| util_thresh_i | input | UTIL_W | Utilization level below which aggressive mode is allowed |
| stagger_i | input | STAG_W | Extra base units inserted after each wake start |
| grant_o | output | NC | One-cycle wake-start permission per core |
| mode_o | output | NC | Granted mode per core, 1 = aggressive, valid with grant_o |

## Verification
The hardest situation to reach from the ports is a requester whose mode depends on a particular set of other cores being mid-wake at the moment it is picked. The bench builds every possible waking set first: it requests those cores and lets them be granted, but withholds their completion. It then raises a single request from each core outside that set, with the utilization set just below and exactly at the threshold. A second hard case is a pending core that loses idle status between capture and arbitration. The bench drops that core's idle bit in the cycle right after the capture edge, so the round-robin pointer is already aimed at it.

// File: rtl/wsa_pkg.sv
package wsa_pkg;

  typedef enum logic {
    MODE_CONS = 1'b0,
    MODE_AGGR = 1'b1
  } wake_mode_e;

  // Manhattan distance 1 on a row-major grid of width gx
  function automatic bit grid_adjacent(int a, int b, int gx);
    int ax, ay, bx, by, dx, dy;
    ax = a % gx;
    ay = a / gx;
    bx = b % gx;
    by = b / gx;
    dx = (ax > bx) ? ax - bx : bx - ax;
    dy = (ay > by) ? ay - by : by - ay;
    return (dx + dy) == 1;
  endfunction

endpackage

// File: rtl/wsa_rr_pick.sv
module wsa_rr_pick #(
  parameter int NC    = 4,
  parameter int IDX_W = 2
) (
  input  logic [NC-1:0]    elig_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);

  // scan from farthest to nearest so the nearest eligible core wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = NC - 1; k >= 0; k--) begin
      int c;
      c = int'(ptr_i) + k;
      if (c >= NC) c = c - NC;
      if (elig_i[c]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(c);
      end
    end
  end

endmodule

// File: rtl/wsa_stagger_timer.sv
module wsa_stagger_timer #(
  parameter int STAG_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [STAG_W-1:0] load_i,
  output logic              ready_o
);

  logic [STAG_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (fire_i) begin
      cnt_q <= load_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready_o = (cnt_q == '0);

endmodule

// File: rtl/wsa_mode_sel.sv
module wsa_mode_sel
  import wsa_pkg::*;
#(
  parameter int NC     = 4,
  parameter int GRID_X = 2,
  parameter int IDX_W  = 2,
  parameter int UTIL_W = 8
) (
  input  logic [IDX_W-1:0]  win_idx_i,
  input  logic [NC-1:0]     wake_i,
  input  logic [UTIL_W-1:0] util_i,
  input  logic [UTIL_W-1:0] thresh_i,
  output wake_mode_e        mode_o
);

  logic [NC-1:0] adj_tab [NC];
  logic [NC-1:0] adj_hits;
  logic          low_util;

  for (genvar i = 0; i < NC; i++) begin : g_row
    for (genvar j = 0; j < NC; j++) begin : g_col
      assign adj_tab[i][j] = grid_adjacent(i, j, GRID_X) ? 1'b1 : 1'b0;
    end
  end

  assign adj_hits = adj_tab[win_idx_i] & wake_i;
  assign low_util = (util_i < thresh_i);
  assign mode_o   = (low_util && adj_hits == '0) ? MODE_AGGR : MODE_CONS;

endmodule

// File: rtl/wake_stagger_arbiter.sv
module wake_stagger_arbiter
  import wsa_pkg::*;
#(
  parameter int GRID_X = 2,
  parameter int GRID_Y = 2,
  parameter int UTIL_W = 8,
  parameter int STAG_W = 2,
  localparam int NC    = GRID_X * GRID_Y,
  localparam int IDX_W = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NC-1:0]     idle_i,
  input  logic [NC-1:0]     req_i,
  input  logic [NC-1:0]     done_i,
  input  logic [UTIL_W-1:0] util_i,
  input  logic [UTIL_W-1:0] util_thresh_i,
  input  logic [STAG_W-1:0] stagger_i,
  output logic [NC-1:0]     grant_o,
  output logic [NC-1:0]     mode_o
);

  logic [NC-1:0]    pend_q, wake_q, grant_q, mode_q;
  logic [NC-1:0]    elig, win_vec, accept;
  logic [IDX_W-1:0] ptr_q, win_idx, ptr_next;
  logic             found, gap_ok, fire;
  wake_mode_e       win_mode;

  assign elig = pend_q & idle_i & ~wake_q;

  wsa_rr_pick #(
    .NC   (NC),
    .IDX_W(IDX_W)
  ) u_pick (
    .elig_i (elig),
    .ptr_i  (ptr_q),
    .found_o(found),
    .idx_o  (win_idx)
  );

  wsa_stagger_timer #(
    .STAG_W(STAG_W)
  ) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .load_i (stagger_i),
    .ready_o(gap_ok)
  );

  wsa_mode_sel #(
    .NC    (NC),
    .GRID_X(GRID_X),
    .IDX_W (IDX_W),
    .UTIL_W(UTIL_W)
  ) u_mode (
    .win_idx_i(win_idx),
    .wake_i   (wake_q),
    .util_i   (util_i),
    .thresh_i (util_thresh_i),
    .mode_o   (win_mode)
  );

  assign fire = found & gap_ok;

  always_comb begin
    win_vec = '0;
    if (fire) win_vec[win_idx] = 1'b1;
  end

  assign ptr_next = (win_idx == IDX_W'(NC - 1)) ? '0 : win_idx + 1'b1;

  // winner is masked so a held request cannot re-arm it on the grant edge
  assign accept = req_i & idle_i & ~wake_q & ~win_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      wake_q  <= '0;
      grant_q <= '0;
      mode_q  <= '0;
      ptr_q   <= '0;
    end else begin
      pend_q  <= (pend_q | accept) & ~win_vec;
      wake_q  <= (wake_q & ~done_i) | win_vec;
      grant_q <= win_vec;
      mode_q  <= (win_mode == MODE_AGGR) ? win_vec : '0;
      if (fire) ptr_q <= ptr_next;
    end
  end

  assign grant_o = grant_q;
  assign mode_o  = mode_q;

endmodule

// File: rtl/wake_stagger_arbiter_chk.sv
module wake_stagger_arbiter_chk #(
  parameter int NC     = 4,
  parameter int UTIL_W = 8,
  parameter int STAG_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NC-1:0]     idle_i,
  input logic [UTIL_W-1:0] util_i,
  input logic [UTIL_W-1:0] util_thresh_i,
  input logic [STAG_W-1:0] stagger_i,
  input logic [NC-1:0]     grant_o,
  input logic [NC-1:0]     mode_o
);

  logic [STAG_W-1:0] stag_d, gap_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stag_d <= '0;
      gap_c  <= '0;
    end else begin
      stag_d <= stagger_i;
      if (|grant_o)         gap_c <= stag_d;
      else if (gap_c != '0) gap_c <= gap_c - 1'b1;
    end
  end

  a_r3_one_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  a_r3_stagger_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grant_o) |-> (gap_c == '0));

  a_r6_idle_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~$past(idle_i)) == '0);

  a_r5_aggr_util: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mode_o) |-> $past(util_i < util_thresh_i));

  a_r5_mode_with_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o & ~grant_o) == '0);

  a_r7_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & $past(grant_o)) == '0);

endmodule

bind wake_stagger_arbiter wake_stagger_arbiter_chk #(
  .NC    (NC),
  .UTIL_W(UTIL_W),
  .STAG_W(STAG_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .idle_i       (idle_i),
  .util_i       (util_i),
  .util_thresh_i(util_thresh_i),
  .stagger_i    (stagger_i),
  .grant_o      (grant_o),
  .mode_o       (mode_o)
);

// File: tb/wake_stagger_arbiter_tb.sv
module wake_stagger_arbiter_tb;

  localparam int CLK_P  = 10;
  localparam int NC     = 4;
  localparam int UTIL_W = 4;
  localparam int STAG_W = 2;
  localparam int THR    = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NC-1:0]     idle = '1, req = '0, done = '0;
  logic [UTIL_W-1:0] util = '0, thresh = UTIL_W'(THR);
  logic [STAG_W-1:0] stagger = '0;
  logic [NC-1:0]     grant, mode;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int gcnt [NC];
  int gcyc [NC];
  int gmode[NC];
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wake_stagger_arbiter #(
    .GRID_X(2), .GRID_Y(2), .UTIL_W(UTIL_W), .STAG_W(STAG_W)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .idle_i(idle), .req_i(req), .done_i(done),
    .util_i(util), .util_thresh_i(thresh), .stagger_i(stagger),
    .grant_o(grant), .mode_o(mode)
  );

  always @(posedge clk) begin
    #(CLK_P/4);
    cyc++;
    for (int i = 0; i < NC; i++) begin
      if (grant[i]) begin
        gcnt[i]++;
        gcyc[i]  = cyc;
        gmode[i] = int'(mode[i]);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_logs();
    for (int i = 0; i < NC; i++) begin
      gcnt[i] = 0; gcyc[i] = 0; gmode[i] = -1;
    end
  endtask

  task automatic req_pulse(input logic [NC-1:0] m);
    @(negedge clk); req = m;
    @(negedge clk); req = '0;
  endtask

  task automatic done_pulse(input logic [NC-1:0] m);
    @(negedge clk); done = m;
    @(negedge clk); done = '0;
  endtask

  function automatic bit adjacent(int a, int b);
    return $countones(a ^ b) == 1;
  endfunction

  initial begin
    clr_logs();
    tick(3);
    check(grant == '0, "R1 grant at reset", int'(grant), 0);
    check(mode == '0, "R1 mode at reset", int'(mode), 0);
    rst_n = 1'b1;
    util = 4'd15;

    // R3 / R4 / R1: all four contend, every stagger value
    for (int s = 0; s < 4; s++) begin
      stagger = STAG_W'(s);
      clr_logs();
      req_pulse(4'hF);
      tick(4 * (s + 1) + 6);
      for (int k = 0; k < NC; k++) begin
        check(gcnt[k] == 1, "R3 one start per core", gcnt[k], 1);
        check(gmode[k] == 0, "R5 high util conservative", gmode[k], 0);
      end
      for (int k = 1; k < NC; k++)
        check(gcyc[k] - gcyc[0] == k * (s + 1), "R3 R4 stagger spacing and order",
              gcyc[k] - gcyc[0], k * (s + 1));
      done_pulse(4'hF);
      tick(3);
    end

    // R2: latency and pulse width, core 1
    stagger = '0;
    util = 4'd2;
    @(negedge clk); req = 4'b0010;
    @(negedge clk); req = '0;
    check(grant == '0, "R2 no grant one cycle after request", int'(grant), 0);
    @(negedge clk);
    check(grant == 4'b0010, "R2 grant after second edge", int'(grant), 2);
    check(mode == 4'b0010, "R5 aggressive alone at low util", int'(mode), 2);
    @(negedge clk);
    check(grant == '0, "R2 single-cycle pulse", int'(grant), 0);
    done_pulse(4'b0010);

    // R2: held request gives one grant (core 3)
    clr_logs();
    @(negedge clk); req = 4'b1000;
    tick(3);
    req = '0;
    tick(4);
    check(gcnt[3] == 1, "R2 held request single grant", gcnt[3], 1);
    done_pulse(4'b1000);

    // R4: wrap-around, last winner core 1 -> search from 2
    req_pulse(4'b0010);
    tick(3);
    done_pulse(4'b0010);
    clr_logs();
    req_pulse(4'b1001);
    tick(5);
    check(gcnt[3] == 1 && gcnt[0] == 1, "R4 both served", gcnt[3] + gcnt[0], 2);
    check(gcyc[3] < gcyc[0], "R4 core 3 before core 0", gcyc[3], gcyc[0] - 1);
    done_pulse(4'b1001);

    // R6: pending core loses idle before arbitration (pointer at 1)
    clr_logs();
    stagger = 2'd3;
    @(negedge clk); req = 4'b0110;
    @(negedge clk); req = '0; idle = 4'b1101;
    tick(8);
    check(gcnt[2] == 1, "R6 other core served", gcnt[2], 1);
    check(gcnt[1] == 0, "R6 non-idle pending core skipped", gcnt[1], 0);
    idle = '1;
    tick(6);
    check(gcnt[1] == 1, "R6 pending kept until idle", gcnt[1], 1);
    done_pulse(4'b0110);
    stagger = '0;
    tick(4);

    // R6: request from non-idle core ignored
    clr_logs();
    idle = 4'b1011;
    req_pulse(4'b0100);
    tick(4);
    idle = '1;
    tick(5);
    check(gcnt[2] == 0, "R6 non-idle request ignored", gcnt[2], 0);

    // R7: waking core cannot be granted again until done
    clr_logs();
    req_pulse(4'b0001);
    tick(3);
    req_pulse(4'b0001);
    tick(4);
    check(gcnt[0] == 1, "R7 request while waking ignored", gcnt[0], 1);
    done_pulse(4'b0001);
    req_pulse(4'b0001);
    tick(3);
    check(gcnt[0] == 2, "R7 served after done", gcnt[0], 2);
    done_pulse(4'b0001);

    // R5: every waking set x every outside requester x util at/below threshold
    for (int w = 0; w < 16; w++) begin
      for (int r = 0; r < NC; r++) begin
        if (w[r]) continue;
        for (int u = THR - 1; u <= THR; u++) begin
          bit adj_busy;
          int exp_m;
          adj_busy = 1'b0;
          for (int j = 0; j < NC; j++)
            if (w[j] && adjacent(r, j)) adj_busy = 1'b1;
          exp_m = (u < THR && !adj_busy) ? 1 : 0;
          util = UTIL_W'(u);
          if (w != 0) begin
            req_pulse(NC'(w));
            tick(6);
          end
          clr_logs();
          req_pulse(NC'(1 << r));
          tick(3);
          check(gcnt[r] == 1, "R5 sweep grant", gcnt[r], 1);
          check(gmode[r] == exp_m, "R5 sweep mode", gmode[r], exp_m);
          done_pulse(4'hF);
          tick(1);
        end
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule